// File: doc/BRIEF.md
# All-Digital Phase-Locked Loop with Proportional-Integral Filter

This block pulls an internal numerically controlled oscillator into phase with an external reference strobe. Everything runs on one system clock. Each clock in which `ref_in` is high counts as one reference edge. A phase comparator turns the distance between a reference edge and the nearest oscillator feedback edge into a single signed error sample. A proportional-integral filter turns that sample into a signed control word. The control word is added to a programmable nominal step that drives a phase accumulator, and the accumulator's carry is the output clock-enable pulse.

An integer divider, chosen at elaboration, can sit between the oscillator and the comparator. The comparator then sees only every N-th oscillator pulse. Loop gains are power-of-two right shifts. The integrator can optionally leak a fixed binary fraction of its value on every sample.

A lock flag reports a sustained run of small errors.

Top module: `dpll_core`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `clk_en` is 0, `ctrl_word` is 0 and `locked` is 0. The integrator is cleared. The feedback-age counter starts at its maximum (255).
- R2: The oscillator adds its increment to a 16-bit phase register on every clock. `clk_en` is high for the one cycle after each edge at which the sum reaches 2^16 or more. With a step of 1024 and a zero control word, pulses appear at edges 64, 128, and so on after reset is released.
- R3: The oscillator increment equals `nom_step` plus the sign-extended `ctrl_word`, limited to the range 0 to 2^16-1. An increment limited to 0 produces no pulses.
- R4: The phase error is clamped to ±`half_window`, where `half_window` is at least 1.
  - If a reference edge arrives d clocks after the last feedback edge and d ≤ `half_window`, the sample is -d.
  - If d > `half_window`, the comparator waits for the next feedback edge and reports +k, where k is the number of clocks after the reference edge. If k reaches `half_window` first, it reports +`half_window`.
  - A reference edge and a feedback edge in the same cycle give 0.
  - The sample is registered one clock after the deciding edge.
- R5: On each sample, the integrator adds the signed error to its stored value. The result saturates at -2048 and +2047 instead of wrapping.
- R6: With `leak_en` high, the stored value v is first replaced by v - (v >>> 3), an arithmetic shift, before the error is added.
- R7: On each sample, `ctrl_word` becomes (integrator >>> `ki_shift`) + (error >>> `kp_shift`), using the updated integrator value and saturated to -512..511. It changes on the clock edge after the sample register is loaded.
- R8: With the default divider of 2, the comparator sees only every second oscillator pulse as a feedback edge.
- R9: `locked` rises on the 16th consecutive sample whose absolute value is below `lock_thresh`. It drops on any sample with absolute value at or above `lock_thresh`.
- R10: On clocks without a sample, the integrator, `ctrl_word` and `locked` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference strobe, one reference edge per high cycle |
| nom_step | input | 16 | Nominal oscillator phase increment |
| half_window | input | 7 | Error clamp, half the nominal feedback period in clocks |
| kp_shift | input | 4 | Right shift applied to the proportional term |
| ki_shift | input | 4 | Right shift applied to the integrator output |
| leak_en | input | 1 | Enables the leaky integrator |
| lock_thresh | input | 7 | Absolute error bound for lock qualification |
| clk_en | output | 1 | Generated clock-enable pulse train |
| ctrl_word | output | 10 | Signed control word |
| locked | output | 1 | Lock indication |

## Verification
The hardest condition to reach from the ports is a saturated integrator that can be told apart from a merely saturated control word. The stimulus gets there in three steps. First, it fires every reference edge exactly `half_window` clocks after the bench's own prediction of the feedback edge, so every sample carries the most negative legal error. Second, once the control word has pinned, it raises the integral shift so the clipped integrator value appears exactly in `ctrl_word`. Third, it enables the leak under the same error stream and shows the control word settling well inside its limit. A separate step starves the oscillator with a small nominal step so that unanswered reference edges run into the timeout clamp.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

    localparam int ERR_W = 8;

    typedef enum logic {
        PD_IDLE,
        PD_WAIT
    } pd_state_t;

    typedef struct packed {
        logic                    valid;
        logic signed [ERR_W-1:0] value;
    } err_sample_t;

    // Clamp a signed value to the range of a w-bit two's complement word.
    function automatic logic signed [31:0] sat_to(input logic signed [31:0] v, input int w);
        logic signed [31:0] hi;
        logic signed [31:0] lo;
        hi = (32'sd1 <<< (w - 1)) - 32'sd1;
        lo = -hi - 32'sd1;
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic logic [ERR_W-1:0] err_mag(input logic signed [ERR_W-1:0] e);
        return e[ERR_W-1] ? ERR_W'(-e) : ERR_W'(e);
    endfunction

endpackage

// File: rtl/dpll_phase_det.sv
module dpll_phase_det
    import dpll_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_ev,
    input  logic              fb_ev,
    input  logic [ERR_W-2:0]  half_window,
    output err_sample_t       smp
);

    localparam logic [ERR_W-1:0] AGE_MAX = '1;

    pd_state_t        state_q;
    logic [ERR_W-1:0] since_fb_q;
    logic [ERR_W-1:0] wait_cnt_q;
    logic [ERR_W-1:0] limit;

    assign limit = {1'b0, half_window};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= PD_IDLE;
            since_fb_q <= AGE_MAX;
            wait_cnt_q <= '0;
            smp        <= '0;
        end else begin
            smp.valid  <= 1'b0;
            since_fb_q <= fb_ev ? ERR_W'(1) :
                          ((since_fb_q == AGE_MAX) ? since_fb_q : since_fb_q + 1'b1);
            if (ref_ev && fb_ev) begin
                smp.valid <= 1'b1;
                smp.value <= '0;
                state_q   <= PD_IDLE;
            end else if (ref_ev) begin
                if (since_fb_q <= limit) begin
                    // oscillator edge came first: it leads
                    smp.valid <= 1'b1;
                    smp.value <= -$signed(since_fb_q);
                    state_q   <= PD_IDLE;
                end else begin
                    state_q    <= PD_WAIT;
                    wait_cnt_q <= ERR_W'(1);
                end
            end else if (state_q == PD_WAIT) begin
                if (fb_ev || (wait_cnt_q >= limit)) begin
                    // oscillator lags, or the window ran out
                    smp.valid <= 1'b1;
                    smp.value <= $signed(wait_cnt_q);
                    state_q   <= PD_IDLE;
                end else begin
                    wait_cnt_q <= wait_cnt_q + 1'b1;
                end
            end
        end
    end

    assert_err_clamp_R4: assert property (@(posedge clk) disable iff (rst)
        smp.valid |-> (($signed(smp.value) <= $signed(limit)) &&
                       ($signed(smp.value) >= -$signed(limit))))
        else $error("phase error outside the clamp window");

endmodule

// File: rtl/dpll_loop_filter.sv
module dpll_loop_filter
    import dpll_pkg::*;
#(
    parameter int INT_W      = 12,
    parameter int CTRL_W     = 10,
    parameter int LEAK_SHIFT = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  err_sample_t              smp,
    input  logic [3:0]               kp_shift,
    input  logic [3:0]               ki_shift,
    input  logic                     leak_en,
    output logic signed [CTRL_W-1:0] ctrl_word
);

    logic signed [INT_W-1:0]  acc_q;
    logic signed [INT_W-1:0]  leaked;
    logic signed [INT_W-1:0]  acc_n;
    logic signed [CTRL_W-1:0] ctrl_n;
    logic signed [ERR_W-1:0]  e;

    assign e = smp.value;

    always_comb begin
        leaked = leak_en ? (acc_q - (acc_q >>> LEAK_SHIFT)) : acc_q;
        acc_n  = INT_W'(sat_to(32'(leaked) + 32'(e), INT_W));
        ctrl_n = CTRL_W'(sat_to(32'(acc_n >>> ki_shift) + 32'(e >>> kp_shift), CTRL_W));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            ctrl_word <= '0;
        end else if (smp.valid) begin
            acc_q     <= acc_n;
            ctrl_word <= ctrl_n;
        end
    end

    assert_ctrl_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(smp.valid)) |-> $stable(ctrl_word))
        else $error("control word moved without a sample");

    assert_acc_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(smp.valid)) |-> $stable(acc_q))
        else $error("integrator moved without a sample");

endmodule

// File: rtl/dpll_lock_det.sv
module dpll_lock_det
    import dpll_pkg::*;
#(
    parameter int LOCK_RUN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  err_sample_t       smp,
    input  logic [ERR_W-2:0]  lock_thresh,
    output logic              locked
);

    localparam int CW = $clog2(LOCK_RUN + 1);
    localparam logic [CW-1:0] RUN_END  = CW'(LOCK_RUN);
    localparam logic [CW-1:0] RUN_LAST = CW'(LOCK_RUN - 1);

    logic [CW-1:0] run_q;
    logic          small_err;

    assign small_err = err_mag(smp.value) < {1'b0, lock_thresh};

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            locked <= 1'b0;
        end else if (smp.valid) begin
            if (small_err) begin
                if (run_q != RUN_END) run_q <= run_q + 1'b1;
                locked <= (run_q >= RUN_LAST);
            end else begin
                run_q  <= '0;
                locked <= 1'b0;
            end
        end
    end

    assert_lock_on_sample_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(smp.valid))
        else $error("lock rose without a sample");

endmodule

// File: rtl/dpll_nco.sv
module dpll_nco #(
    parameter int ACC_W  = 16,
    parameter int CTRL_W = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ACC_W-1:0]         nom_step,
    input  logic signed [CTRL_W-1:0] ctrl_word,
    output logic                     pulse
);

    localparam logic signed [31:0] INC_MAX = (32'sd1 <<< ACC_W) - 32'sd1;

    logic [ACC_W-1:0]   phase_q;
    logic [ACC_W-1:0]   inc;
    logic [ACC_W:0]     sum;
    logic signed [31:0] inc_w;

    always_comb begin
        inc_w = $signed(32'(nom_step)) + 32'(ctrl_word);
        if (inc_w < 0)            inc = '0;
        else if (inc_w > INC_MAX) inc = '1;
        else                      inc = ACC_W'(inc_w);
        sum = {1'b0, phase_q} + {1'b0, inc};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            pulse   <= 1'b0;
        end else begin
            phase_q <= sum[ACC_W-1:0];
            pulse   <= sum[ACC_W];
        end
    end

    assert_carry_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && pulse) |-> (phase_q < $past(inc)))
        else $error("pulse without phase wrap");

    assert_no_carry_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !pulse) |-> (phase_q >= $past(inc)))
        else $error("phase wrapped without pulse");

endmodule

// File: rtl/dpll_core.sv
module dpll_core
    import dpll_pkg::*;
#(
    parameter int ACC_W      = 16,
    parameter int INT_W      = 12,
    parameter int CTRL_W     = 10,
    parameter int LEAK_SHIFT = 3,
    parameter int DIV_N      = 2,
    parameter int LOCK_RUN   = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ref_in,
    input  logic [ACC_W-1:0]         nom_step,
    input  logic [ERR_W-2:0]         half_window,
    input  logic [3:0]               kp_shift,
    input  logic [3:0]               ki_shift,
    input  logic                     leak_en,
    input  logic [ERR_W-2:0]         lock_thresh,
    output logic                     clk_en,
    output logic signed [CTRL_W-1:0] ctrl_word,
    output logic                     locked
);

    err_sample_t smp;
    logic        osc_pulse;
    logic        fb_ev;

    dpll_phase_det u_pd (
        .clk         (clk),
        .rst         (rst),
        .ref_ev      (ref_in),
        .fb_ev       (fb_ev),
        .half_window (half_window),
        .smp         (smp)
    );

    dpll_loop_filter #(
        .INT_W      (INT_W),
        .CTRL_W     (CTRL_W),
        .LEAK_SHIFT (LEAK_SHIFT)
    ) u_filt (
        .clk       (clk),
        .rst       (rst),
        .smp       (smp),
        .kp_shift  (kp_shift),
        .ki_shift  (ki_shift),
        .leak_en   (leak_en),
        .ctrl_word (ctrl_word)
    );

    dpll_lock_det #(
        .LOCK_RUN (LOCK_RUN)
    ) u_lock (
        .clk         (clk),
        .rst         (rst),
        .smp         (smp),
        .lock_thresh (lock_thresh),
        .locked      (locked)
    );

    dpll_nco #(
        .ACC_W  (ACC_W),
        .CTRL_W (CTRL_W)
    ) u_nco (
        .clk       (clk),
        .rst       (rst),
        .nom_step  (nom_step),
        .ctrl_word (ctrl_word),
        .pulse     (osc_pulse)
    );

    assign clk_en = osc_pulse;

    generate
        if (DIV_N > 1) begin : g_div
            localparam int DW = $clog2(DIV_N);
            localparam logic [DW-1:0] LAST = DW'(DIV_N - 1);
            logic [DW-1:0] div_q;

            always_ff @(posedge clk) begin
                if (rst)            div_q <= '0;
                else if (osc_pulse) div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
            end

            assign fb_ev = osc_pulse && (div_q == LAST);

            assert_div_spacing_R8: assert property (@(posedge clk) disable iff (rst)
                fb_ev |=> !fb_ev)
                else $error("feedback edges on adjacent clocks with divider active");
        end else begin : g_nodiv
            assign fb_ev = osc_pulse;
        end
    endgenerate

endmodule

// File: tb/dpll_core_test.sv
`timescale 1ns/1ps
module dpll_core_test;

    localparam int DIV      = 2;
    localparam int INT_MAX  = 2047;
    localparam int CTRL_MAX = 511;
    localparam int PH_MOD   = 65536;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ref_in = 1'b0;
    logic [15:0]       nom_step = 16'd1024;
    logic [6:0]        half_window = 7'd64;
    logic [3:0]        kp_shift = 4'd2;
    logic [3:0]        ki_shift = 4'd2;
    logic              leak_en = 1'b0;
    logic [6:0]        lock_thresh = 7'd3;
    wire               clk_en;
    wire signed [9:0]  ctrl_word;
    wire               locked;

    always #10 clk = ~clk;

    dpll_core uut (
        .clk         (clk),
        .rst         (rst),
        .ref_in      (ref_in),
        .nom_step    (nom_step),
        .half_window (half_window),
        .kp_shift    (kp_shift),
        .ki_shift    (ki_shift),
        .leak_en     (leak_en),
        .lock_thresh (lock_thresh),
        .clk_en      (clk_en),
        .ctrl_word   (ctrl_word),
        .locked      (locked)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    bit    cmp_on = 1'b0;
    string cur_req = "R1";
    int    ref_mode = 0;   // 0 off, 1 follow feedback, 2 fixed lag, 3 every pulse, 4 periodic
    int    ref_lag = 5;
    int    ref_period = 150;
    int    lag_cnt = 0;
    int    per_cnt = 0;

    // behavioural model state
    int m_phase, m_osc, m_div, m_since, m_wait, m_wcnt, m_ev, m_err;
    int m_acc, m_ctrl, m_run, m_lock;

    function automatic int clip(input int v, input int hi);
        if (v > hi) return hi;
        if (v < -hi - 1) return -hi - 1;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int fb, l, na, nc, mag, inc, s;
        int n_ev, n_err, n_wait, n_wcnt, n_since;
        if (rst) begin
            m_phase = 0; m_osc = 0; m_div = 0; m_since = 255; m_wait = 0;
            m_wcnt = 0; m_ev = 0; m_err = 0; m_acc = 0; m_ctrl = 0;
            m_run = 0; m_lock = 0;
        end else begin
            fb = (m_osc != 0 && m_div == DIV - 1) ? 1 : 0;
            // filter and lock on the registered sample
            if (m_ev != 0) begin
                l  = leak_en ? (m_acc - (m_acc >>> 3)) : m_acc;
                na = clip(l + m_err, INT_MAX);
                nc = clip((na >>> ki_shift) + (m_err >>> kp_shift), CTRL_MAX);
                mag = (m_err < 0) ? -m_err : m_err;
                if (mag < int'(lock_thresh)) begin
                    if (m_run < 16) m_run = m_run + 1;
                    m_lock = (m_run >= 16) ? 1 : 0;
                end else begin
                    m_run = 0;
                    m_lock = 0;
                end
                m_acc = na;
            end else begin
                nc = m_ctrl;
            end
            // comparator
            n_ev = 0; n_err = m_err; n_wait = m_wait; n_wcnt = m_wcnt;
            n_since = fb ? 1 : ((m_since < 255) ? m_since + 1 : 255);
            if (ref_in && fb) begin
                n_ev = 1; n_err = 0; n_wait = 0;
            end else if (ref_in) begin
                if (m_since <= int'(half_window)) begin
                    n_ev = 1; n_err = -m_since; n_wait = 0;
                end else begin
                    n_wait = 1; n_wcnt = 1;
                end
            end else if (m_wait != 0) begin
                if (fb || m_wcnt >= int'(half_window)) begin
                    n_ev = 1; n_err = m_wcnt; n_wait = 0;
                end else begin
                    n_wcnt = m_wcnt + 1;
                end
            end
            // oscillator with the old control word
            inc = int'(nom_step) + m_ctrl;
            if (inc < 0) inc = 0;
            if (inc > PH_MOD - 1) inc = PH_MOD - 1;
            s = m_phase + inc;
            if (m_osc != 0) m_div = (m_div == DIV - 1) ? 0 : m_div + 1;
            m_osc = (s >= PH_MOD) ? 1 : 0;
            m_phase = s % PH_MOD;
            m_ctrl = nc;
            m_ev = n_ev; m_err = n_err; m_wait = n_wait; m_wcnt = n_wcnt; m_since = n_since;
        end
    end

    // compare every clock, then drive the reference strobe
    always @(negedge clk) begin
        int fb_now;
        if (cmp_on) begin
            chk(int'(clk_en) == m_osc, cur_req, "clk_en", int'(clk_en), m_osc);
            chk(int'(ctrl_word) == m_ctrl, cur_req, "ctrl_word", int'(ctrl_word), m_ctrl);
            chk(int'(locked) == m_lock, cur_req, "locked", int'(locked), m_lock);
        end
        fb_now = (m_osc != 0 && m_div == DIV - 1) ? 1 : 0;
        if (fb_now != 0) lag_cnt = 0; else lag_cnt = lag_cnt + 1;
        per_cnt = (per_cnt >= ref_period - 1) ? 0 : per_cnt + 1;
        case (ref_mode)
            1:       ref_in <= (fb_now != 0);
            2:       ref_in <= (fb_now == 0) && (lag_cnt == ref_lag);
            3:       ref_in <= (m_osc != 0);
            4:       ref_in <= (per_cnt == 0);
            default: ref_in <= 1'b0;
        endcase
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int pulses;
        int held;
        bit steady;

        // R1: reset state
        @(negedge clk);
        cmp_on = 1'b1;
        run(3);
        chk(clk_en == 1'b0, "R1", "clk_en in reset", int'(clk_en), 0);
        chk(ctrl_word == 10'sd0, "R1", "ctrl_word in reset", int'(ctrl_word), 0);
        chk(locked == 1'b0, "R1", "locked in reset", int'(locked), 0);
        rst = 1'b0;

        // R2: free run at step 1024, one pulse every 64 clocks
        cur_req = "R2";
        pulses = 0;
        for (int i = 0; i < 640; i++) begin
            @(negedge clk);
            if (clk_en) pulses++;
        end
        chk(pulses == 10, "R2", "pulses in 640 clocks", pulses, 10);

        // R8 and R9: reference aligned to every second oscillator pulse
        cur_req = "R8";
        ref_mode = 1;
        run(2560);
        chk(locked == 1'b1, "R9", "locked after aligned samples", int'(locked), 1);
        chk(ctrl_word == 10'sd0, "R8", "ctrl with zero error", int'(ctrl_word), 0);

        // R8/R9: reference on every oscillator pulse breaks lock
        cur_req = "R9";
        ref_mode = 3;
        run(300);
        chk(locked == 1'b0, "R9", "lock cleared by large error", int'(locked), 0);

        // R4/R7: oscillator leads by 5 clocks
        cur_req = "R4";
        kp_shift = 4'd0;
        ki_shift = 4'd15;
        ref_lag = 5;
        ref_mode = 2;
        run(1500);
        chk(ctrl_word == -10'sd6, "R7", "ctrl = (acc>>>15) + err", int'(ctrl_word), -6);

        // R4: oscillator lags; reference 100 clocks after feedback
        ref_lag = 100;
        run(1500);

        // R5: maximum negative error drives the integrator to its floor
        cur_req = "R5";
        kp_shift = 4'd0;
        ki_shift = 4'd0;
        ref_lag = 64;
        run(18000);
        chk(ctrl_word == -10'sd512, "R5", "ctrl pinned", int'(ctrl_word), -512);
        cur_req = "R7";
        ki_shift = 4'd3;
        kp_shift = 4'd15;
        run(600);
        chk(ctrl_word == -10'sd257, "R5", "saturated integrator seen via shift", int'(ctrl_word), -257);

        // R6: leak pulls the integrator back from its floor
        cur_req = "R6";
        leak_en = 1'b1;
        ki_shift = 4'd1;
        run(8000);
        chk(ctrl_word > -10'sd300 && ctrl_word < -10'sd200, "R6", "leaky ctrl settles", int'(ctrl_word), -257);
        chk(int'(ctrl_word) == m_ctrl, "R6", "leaky ctrl vs model", int'(ctrl_word), m_ctrl);

        // R10: no reference, nothing moves
        cur_req = "R10";
        ref_mode = 0;
        run(100);
        held = int'(ctrl_word);
        steady = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (int'(ctrl_word) != held || locked != 1'b0) steady = 1'b0;
        end
        chk(steady, "R10", "ctrl held without samples", int'(ctrl_word), held);

        // R3: increment clipped at zero stops the oscillator
        cur_req = "R3";
        leak_en = 1'b0;
        kp_shift = 4'd0;
        ki_shift = 4'd0;
        nom_step = 16'd100;
        run(5);
        pulses = 0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (clk_en) pulses++;
        end
        chk(pulses == 0, "R3", "pulses with clipped increment", pulses, 0);

        // R4/R3: unanswered references hit the timeout clamp and restart the oscillator
        cur_req = "R4";
        ref_period = 150;
        ref_mode = 4;
        run(2000);
        chk(ctrl_word > 10'sd0, "R4", "ctrl positive after timeout samples", int'(ctrl_word), 1);

        cur_req = "R3";
        nom_step = 16'd65500;
        run(300);
        ref_mode = 0;
        run(20);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule